// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Gated Non-Maskable Request

This block gathers one-cycle event pulses from the peripherals of a chip and turns them into one interrupt request for the processor. The maskable sources are factors, and factors are grouped into systems. Every factor has its own sticky flag and its own enable bit. Every system has a 2-bit level field. A watchdog pulse forms a separate non-maskable request. That request beats every maskable one, but it is held off after reset until software has written two unlock addresses.

Software reaches the flags, enables and levels through a simple single-cycle register bus. A flag is cleared by writing 1 to its bit. The controller presents the winning vector and its level. The acknowledge input retires a non-maskable request but leaves maskable flags alone. The non-maskable gate is a four-state machine. `GATE_SHUT` moves to `GATE_LO_SEEN` on a write to 0xFF00, or to `GATE_HI_SEEN` on a write to 0xFF01. `GATE_LO_SEEN` moves to `GATE_OPEN` on a write to 0xFF01. `GATE_HI_SEEN` moves to `GATE_OPEN` on a write to 0xFF00. `GATE_OPEN` holds until reset.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pulse on `evt_i[i]` sets flag i on the next clock edge whether or not factor i is enabled. Flags read at address 0x0000, with bit i = flat factor index (systems in ascending order, counts 1,4,2,2,1,3,2,1,1,5, so system 1 holds indices 1..4, system 2 holds 5..6 and system 9 holds 17..21).
- R2: A bus write to 0x0000 clears every flag whose `wdata` bit is 1 and leaves flags whose bit is 0 unchanged. An event arriving on the same cycle as the clear leaves the flag set.
- R3: Enables are read and written at 0x0004, with the same bit positions as the flags. A factor can raise a maskable request only when both its flag and its enable are 1.
- R4: Levels are read and written at 0x0008, with system s at bits 2s+1:2s. Level 0 removes the whole system from arbitration. Levels 1..3 are active, and 3 is the highest.
- R5: A maskable request reaches `irq_req_o` only when its level is strictly greater than `cpu_mask_i`.
- R6: The highest pending level wins. When levels tie, the lower system index wins. Inside a system, the lowest pending factor wins. `irq_vec_o` gives the flat factor index and `irq_lvl_o` gives the system level.
- R7: `irq_ack_i` does not clear any maskable flag.
- R8: After reset, watchdog pulses are dropped until writes to both 0xFF00 and 0xFF01 have been seen, in either order.
- R9: A pending non-maskable request drives `irq_req_o`=1, `irq_vec_o`=22 and `irq_lvl_o`=3, whatever the enables, levels and `cpu_mask_i` hold.
- R10: A watchdog pulse is ignored while `nmi_src_en_i` is 0.
- R11: `irq_ack_i` while the non-maskable request is presented retires that request.
- R12: After reset, all flags, enables and levels read 0 and `irq_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 22 | One-cycle event pulses, one per factor |
| wd_nmi_i | input | 1 | Watchdog non-maskable pulse |
| nmi_src_en_i | input | 1 | Watchdog source enable |
| cpu_mask_i | input | 2 | Current processor interrupt mask level |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 16 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_req_o | output | 1 | Request to the processor |
| irq_vec_o | output | 5 | Winning vector index (22 = non-maskable) |
| irq_lvl_o | output | 2 | Level of the winning request |
| irq_ack_i | input | 1 | Processor acknowledge |

## Verification
The bench builds the controller with its default parameters: ten systems with counts 1,4,2,2,1,3,2,1,1,5, for 22 factors and a 5-bit vector. This layout includes a five-factor system whose indices end at bit 21, so the bench can test lowest-factor selection within a wide system and a level tie between systems of different widths. It also lets the vector value 22 stand for the non-maskable request, just past the last factor. Both unlock orders are covered by running the gate sequence again after a fresh reset.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int MAXSYS = 16;

    typedef enum logic [1:0] {
        GATE_SHUT,
        GATE_LO_SEEN,
        GATE_HI_SEEN,
        GATE_OPEN
    } gate_state_t;

    localparam logic [15:0] ADDR_FLAG    = 16'h0000;
    localparam logic [15:0] ADDR_ENABLE  = 16'h0004;
    localparam logic [15:0] ADDR_LEVEL   = 16'h0008;
    localparam logic [15:0] ADDR_UNLK_LO = 16'hFF00;
    localparam logic [15:0] ADDR_UNLK_HI = 16'hFF01;

    // Sum of the factor counts of systems below index s.
    function automatic int sys_off(input logic [3*MAXSYS-1:0] cnt, input int s);
        int acc;
        acc = 0;
        for (int k = 0; k < MAXSYS; k++)
            if (k < s) acc += int'(cnt[3*k +: 3]);
        return acc;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NFACT = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFACT-1:0] evt,
    input  logic [NFACT-1:0] clr,
    input  logic             en_we,
    input  logic [NFACT-1:0] en_wd,
    output logic [NFACT-1:0] flags,
    output logic [NFACT-1:0] enables,
    output logic [NFACT-1:0] active
);
    for (genvar i = 0; i < NFACT; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (evt[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     enables <= '0;
        else if (en_we) enables <= en_wd;
    end

    assign active = flags & enables;

    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    assert_flag_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags) & ~$past(clr)) == '0));
endmodule

// File: rtl/irq_sys_arb.sv
module irq_sys_arb #(
    parameter int                  NSYS    = 10,
    parameter logic [3*NSYS-1:0]   SYS_CNT = 30'd0,
    parameter int                  NFACT   = 22,
    parameter int                  VW      = 5
) (
    input  logic [NFACT-1:0]  active,
    input  logic [2*NSYS-1:0] levels,
    output logic              win_valid,
    output logic [VW-1:0]     win_vec,
    output logic [1:0]        win_lvl
);
    localparam logic [3*irq_pkg::MAXSYS-1:0] CNT_EXT = (3*irq_pkg::MAXSYS)'(SYS_CNT);

    logic [NSYS-1:0] sys_pend;
    logic [VW-1:0]   sys_vec [NSYS];

    for (genvar s = 0; s < NSYS; s++) begin : g_sys
        localparam int CNT = int'(SYS_CNT[3*s +: 3]);
        localparam int OFF = irq_pkg::sys_off(CNT_EXT, s);
        logic [CNT-1:0] bits;
        logic [VW-1:0]  first;

        assign bits = active[OFF +: CNT];

        always_comb begin
            first = '0;
            for (int f = CNT - 1; f >= 0; f--)
                if (bits[f]) first = VW'(f);
        end

        assign sys_pend[s] = (|bits) && (levels[2*s +: 2] != 2'd0);
        assign sys_vec[s]  = VW'(OFF) + first;
    end

    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_lvl   = 2'd0;
        for (int s = 0; s < NSYS; s++) begin
            if (sys_pend[s] && (levels[2*s +: 2] > win_lvl)) begin
                win_valid = 1'b1;
                win_vec   = sys_vec[s];
                win_lvl   = levels[2*s +: 2];
            end
        end
    end
endmodule

// File: rtl/irq_nmi_gate.sv
module irq_nmi_gate
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_lo,
    input  logic wr_hi,
    input  logic wd_evt,
    input  logic src_en,
    input  logic ack_nmi,
    output logic nmi_pend,
    output logic gate_open
);
    gate_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_SHUT: begin
                if (wr_lo)      state_d = GATE_LO_SEEN;
                else if (wr_hi) state_d = GATE_HI_SEEN;
            end
            GATE_LO_SEEN: if (wr_hi) state_d = GATE_OPEN;
            GATE_HI_SEEN: if (wr_lo) state_d = GATE_OPEN;
            GATE_OPEN:    state_d = GATE_OPEN;
        endcase
    end

    always_comb gate_open = (state_q == GATE_OPEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               nmi_pend <= 1'b0;
        else if (gate_open && wd_evt && src_en)   nmi_pend <= 1'b1;
        else if (ack_nmi)                         nmi_pend <= 1'b0;
    end

    assert_shut_blocks_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GATE_OPEN) |-> !nmi_pend);

    assert_open_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_OPEN) |=> (state_q == GATE_OPEN));

    assert_src_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en |=> !$rose(nmi_pend));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int                NSYS    = 10,
    parameter logic [3*NSYS-1:0] SYS_CNT = {3'd5, 3'd1, 3'd1, 3'd2, 3'd3,
                                            3'd1, 3'd2, 3'd2, 3'd4, 3'd1},
    parameter int                AW      = 16,
    parameter int                DW      = 32,
    localparam int NFACT = irq_pkg::sys_off((3*irq_pkg::MAXSYS)'(SYS_CNT), NSYS),
    localparam int VW    = $clog2(NFACT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFACT-1:0] evt_i,
    input  logic             wd_nmi_i,
    input  logic             nmi_src_en_i,
    input  logic [1:0]       cpu_mask_i,
    input  logic             bus_wr_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [DW-1:0]    bus_rdata_o,
    output logic             irq_req_o,
    output logic [VW-1:0]    irq_vec_o,
    output logic [1:0]       irq_lvl_o,
    input  logic             irq_ack_i
);
    import irq_pkg::*;

    logic [NFACT-1:0]  flags, enables, active, clr;
    logic [2*NSYS-1:0] levels;
    logic              wr_flag, wr_en, wr_lvl, wr_lo, wr_hi;
    logic              win_valid, nmi_pend, gate_open, mask_ok;
    logic [VW-1:0]     win_vec;
    logic [1:0]        win_lvl;

    assign wr_flag = bus_wr_i && (bus_addr_i == AW'(ADDR_FLAG));
    assign wr_en   = bus_wr_i && (bus_addr_i == AW'(ADDR_ENABLE));
    assign wr_lvl  = bus_wr_i && (bus_addr_i == AW'(ADDR_LEVEL));
    assign wr_lo   = bus_wr_i && (bus_addr_i == AW'(ADDR_UNLK_LO));
    assign wr_hi   = bus_wr_i && (bus_addr_i == AW'(ADDR_UNLK_HI));
    assign clr     = wr_flag ? bus_wdata_i[NFACT-1:0] : '0;

    irq_flag_bank #(.NFACT(NFACT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .clr     (clr),
        .en_we   (wr_en),
        .en_wd   (bus_wdata_i[NFACT-1:0]),
        .flags   (flags),
        .enables (enables),
        .active  (active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      levels <= '0;
        else if (wr_lvl) levels <= bus_wdata_i[2*NSYS-1:0];
    end

    irq_sys_arb #(.NSYS(NSYS), .SYS_CNT(SYS_CNT), .NFACT(NFACT), .VW(VW)) u_arb (
        .active    (active),
        .levels    (levels),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_lvl   (win_lvl)
    );

    irq_nmi_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wd_evt    (wd_nmi_i),
        .src_en    (nmi_src_en_i),
        .ack_nmi   (irq_ack_i && nmi_pend),
        .nmi_pend  (nmi_pend),
        .gate_open (gate_open)
    );

    assign mask_ok = win_valid && (win_lvl > cpu_mask_i);

    always_comb begin
        if (nmi_pend) begin
            irq_req_o = 1'b1;
            irq_vec_o = VW'(NFACT);
            irq_lvl_o = 2'd3;
        end else begin
            irq_req_o = mask_ok;
            irq_vec_o = mask_ok ? win_vec : '0;
            irq_lvl_o = mask_ok ? win_lvl : 2'd0;
        end
    end

    always_comb begin
        unique case (bus_addr_i)
            AW'(ADDR_FLAG):   bus_rdata_o = DW'(flags);
            AW'(ADDR_ENABLE): bus_rdata_o = DW'(enables);
            AW'(ADDR_LEVEL):  bus_rdata_o = DW'(levels);
            default:          bus_rdata_o = '0;
        endcase
    end

    assert_nmi_overrides_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> (irq_req_o && (irq_vec_o == VW'(NFACT)) && (irq_lvl_o == 2'd3)));

    assert_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !nmi_pend) |-> (irq_lvl_o > cpu_mask_i));

    assert_req_needs_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !nmi_pend) |-> (flags[irq_vec_o] && enables[irq_vec_o]));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] evt = '0;
    logic        wd = 1'b0, src_en = 1'b1, ack = 1'b0, wr = 1'b0;
    logic [1:0]  mask = 2'd0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        req;
    logic [4:0]  vec;
    logic [1:0]  lvl;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wd_nmi_i(wd), .nmi_src_en_i(src_en),
        .cpu_mask_i(mask), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_req_o(req), .irq_vec_o(vec), .irq_lvl_o(lvl),
        .irq_ack_i(ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata; addr = '0;
    endtask

    task automatic pulse(input logic [21:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    task automatic wd_pulse();
        @(negedge clk); wd = 1'b1;
        @(negedge clk); wd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R12 req", 32'(req), 0);
        bus_read(16'h0000, d); check("R12 flags", d, 0);
        bus_read(16'h0004, d); check("R12 enables", d, 0);
        bus_read(16'h0008, d); check("R12 levels", d, 0);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        pulse(22'h8);
        bus_read(16'h0000, d); check("R1 flag set while disabled", d, 32'h8);
        check("R3 no req when disabled", 32'(req), 0);
        bus_write(16'h0000, 32'h0);
        bus_read(16'h0000, d); check("R2 write 0 keeps", d, 32'h8);
        bus_write(16'h0000, 32'h8);
        bus_read(16'h0000, d); check("R2 write 1 clears", d, 0);
        @(negedge clk); evt = 22'h8; wr = 1'b1; addr = 16'h0000; wdata = 32'h8;
        @(negedge clk); evt = '0; wr = 1'b0; wdata = '0;
        bus_read(16'h0000, d); check("R2 set beats clear", d, 32'h8);
        bus_write(16'h0000, 32'h3F_FFFF);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        bus_write(16'h0004, 32'h8);
        bus_read(16'h0004, d); check("R3 enable readback", d, 32'h8);
        pulse(22'h8);
        check("R4 level 0 blocks", 32'(req), 0);
        bus_write(16'h0008, 32'h8);          // system 1 -> level 2
        check("R3 req", 32'(req), 1);
        check("R6 vec", 32'(vec), 3);
        check("R6 lvl", 32'(lvl), 2);
        @(negedge clk); mask = 2'd2; #1;
        check("R5 equal mask blocks", 32'(req), 0);
        mask = 2'd1; #1;
        check("R5 lower mask passes", 32'(req), 1);
        mask = 2'd0;
        bus_write(16'h0000, 32'h3F_FFFF);
        bus_write(16'h0004, 32'h0);
        bus_write(16'h0008, 32'h0);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        bus_write(16'h0004, 32'h3F_FFFF);
        pulse(22'h0C_0040);                  // factors 18, 19 (sys 9) and 6 (sys 2)
        bus_write(16'h0008, 32'h4_0010);     // sys 9 and sys 2 at level 1
        check("R6 tie lower system", 32'(vec), 6);
        bus_write(16'h0008, 32'hC_0010);     // sys 9 at level 3
        check("R6 higher level", 32'(vec), 18);
        check("R6 lvl3", 32'(lvl), 3);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        bus_read(16'h0000, d); check("R7 ack keeps flags", d, 32'h0C_0040);
        check("R7 vec after ack", 32'(vec), 18);
    endtask

    task automatic t_nmi();
        wd_pulse();
        check("R8 blocked after reset", 32'(vec), 18);
        bus_write(16'hFF01, 32'h0);
        wd_pulse();
        check("R8 one write not enough", 32'(vec), 18);
        bus_write(16'hFF00, 32'h0);
        @(negedge clk); mask = 2'd3;
        wd_pulse();
        check("R9 nmi req", 32'(req), 1);
        check("R9 nmi vec", 32'(vec), 22);
        check("R9 nmi lvl", 32'(lvl), 3);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R11 ack retires nmi", 32'(req), 0);
        src_en = 1'b0;
        wd_pulse();
        check("R10 source disabled", 32'(req), 0);
        src_en = 1'b1; mask = 2'd0;
        do_reset();
        bus_write(16'hFF00, 32'h0);
        wd_pulse();
        check("R8 lo only blocked", 32'(req), 0);
        bus_write(16'hFF01, 32'h0);
        wd_pulse();
        check("R8 lo then hi opens", 32'(vec), 22);
    endtask

    initial begin
        t_reset();
        t_flags();
        t_gate();
        t_arb();
        t_nmi();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule